// File: doc/BRIEF.md
# Conversion Pacer and Trigger Controller

This block decides when the acquisition front end starts a conversion. It emits a single-cycle `convStart` pulse. The pacing source is either an internal divider chain or an external clock pin. The internal chain uses two down counters that step on a slow time-base strobe (nominally 1 MHz, supplied as a one-cycle enable `tickEn`). The upper divider can run alone, or it can drive a lower divider in cascade to give long sample periods.

The pacing is qualified by a digital input in one of three ways. In free-run, that input is not used. In triggered mode, pacing waits for a rising edge on the input and then runs until the master enable drops. In gated mode, pulses pass only while the input is high. One external pin has two uses. When it is selected as the pacer clock, its falling edges pace conversions. Otherwise its rising edges raise an interrupt request, provided the interrupt enable is set. Both external inputs pass through two-flop synchronizers before any edge is detected.

Top module: `pacer_trigger_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `convStart`, `irqOut` and `trigSeen` are 0.
- R2: With internal pacing, cascade off, free-run and master enable set, `convStart` pulses once every `upperReload` ticks of `tickEn`, counted from when the master enable is raised. A reload of 0 or 1 gives a pulse on every tick. The counter reloads itself on each terminal count.
- R3: With cascade on, the lower divider steps once per terminal count of the upper divider, and `convStart` pulses once every `upperReload*lowerReload` ticks. A reload of 0 counts as 1.
- R4: While `masterEn` is 0, no `convStart` pulse occurs and both counters are held at their reload values, so pacing restarts from a full period.
- R5: With `extPaceSel`=1, each falling edge on `xclkIn` gives exactly one `convStart` pulse, on the third clock edge after the pin change. `tickEn` then has no effect.
- R6: With `extPaceSel`=0 and `intEn`=1, each rising edge on `xclkIn` gives one `irqOut` pulse. With `intEn`=0 or `extPaceSel`=1, `irqOut` stays 0.
- R7: Triggered mode is `trigEn`=1 and `gateEn`=0. In this mode no pulse occurs until a rising edge on `trigIn`. After that edge, pacing runs from freshly loaded counters.
- R8: `trigSeen` goes to 1 on the qualifying trigger edge in triggered mode. It returns to 0 only when the master enable or triggered mode is removed.
- R9: Gated mode is `trigEn`=1 and `gateEn`=1. In this mode `convStart` pulses only while `trigIn` is high, and the counters keep running while the gate is low.
- R10: With `trigEn`=0, `gateEn` and `trigIn` have no effect on pacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle time-base strobe |
| masterEn | input | 1 | Master enable for all pacing |
| extPaceSel | input | 1 | 1: `xclkIn` falling edges pace; 0: internal dividers |
| cascadeEn | input | 1 | Chain the lower divider behind the upper |
| trigEn | input | 1 | Digital trigger/gate qualification enable |
| gateEn | input | 1 | With `trigEn`: 1 gated, 0 triggered |
| intEn | input | 1 | External interrupt enable |
| upperReload | input | 16 | Upper divider reload value |
| lowerReload | input | 16 | Lower divider reload value |
| xclkIn | input | 1 | Shared external pacer / interrupt pin (asynchronous) |
| trigIn | input | 1 | Digital trigger / gate pin (asynchronous) |
| convStart | output | 1 | One-cycle conversion start pulse |
| irqOut | output | 1 | One-cycle external interrupt request |
| trigSeen | output | 1 | Trigger-occurred status |

## Verification
The embedded assertions check every cycle that conversion pulses occur only after a cycle with the master enable set, and that pulses in gated mode occur only with the synchronized gate high. They also check that interrupts occur only when the pin is assigned to interrupts, that the trigger flag clears only when its mode or the master enable is withdrawn, and that the counters hold when they receive no strobe. The division ratios in single and cascaded mode, the restart phase after enabling, trigger arming, and the exact three-edge latency of the external pacer can only be shown by the bench. It counts pulses over tick sequences, both directed and seeded random, and compares them with the count computed from the reload values.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int CNT_W = 16;

  // Strobes from control to the divider datapath
  typedef struct packed {
    logic loadUpper;
    logic stepUpper;
    logic loadLower;
    logic stepLower;
  } divStrobes_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic prevLevel;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prevLevel;
  assign fall  = ~chain[STAGES-1] & prevLevel;
endmodule

// File: rtl/pacer_datapath.sv
module pacer_datapath
  import pacer_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  divStrobes_t  stb,
  input  logic [W-1:0] upperReload,
  input  logic [W-1:0] lowerReload,
  output logic         upperTc,
  output logic         lowerTc
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] upperCnt, lowerCnt;

  // Terminal count: the step that consumes the last count
  assign upperTc = stb.stepUpper & (upperCnt <= ONE);
  assign lowerTc = stb.stepLower & (lowerCnt <= ONE);

  always_ff @(posedge clk) begin
    if (!rstN)              upperCnt <= '0;
    else if (stb.loadUpper) upperCnt <= upperReload;
    else if (upperTc)       upperCnt <= upperReload;
    else if (stb.stepUpper) upperCnt <= upperCnt - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              lowerCnt <= '0;
    else if (stb.loadLower) lowerCnt <= lowerReload;
    else if (lowerTc)       lowerCnt <= lowerReload;
    else if (stb.stepLower) lowerCnt <= lowerCnt - ONE;
  end

  // R2
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.stepUpper && !stb.loadUpper) |=> $stable(upperCnt));
  // R3
  lower_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.stepLower && !stb.loadLower) |=> $stable(lowerCnt));
endmodule

// File: rtl/pacer_control.sv
module pacer_control
  import pacer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        masterEn,
  input  logic        extPaceSel,
  input  logic        cascadeEn,
  input  logic        trigEn,
  input  logic        gateEn,
  input  logic        intEn,
  input  logic        xclkIn,
  input  logic        trigIn,
  input  logic        upperTc,
  input  logic        lowerTc,
  output divStrobes_t stb,
  output logic        convStart,
  output logic        irqOut,
  output logic        trigSeen
);
  logic xLevel, xRise, xFall;
  logic gLevel, gRise, gFall;

  edge_sync #(.STAGES(2)) u_xsync (
    .clk(clk), .rstN(rstN), .asyncIn(xclkIn),
    .level(xLevel), .rise(xRise), .fall(xFall));

  edge_sync #(.STAGES(2)) u_tsync (
    .clk(clk), .rstN(rstN), .asyncIn(trigIn),
    .level(gLevel), .rise(gRise), .fall(gFall));

  logic trigMode, gateMode, armed, running, paceEvt, qualEvt;

  assign trigMode = trigEn & ~gateEn;
  assign gateMode = trigEn & gateEn;
  assign armed    = ~trigMode | trigSeen;
  assign running  = masterEn & ~extPaceSel & armed;

  always_comb begin
    stb.loadUpper = ~running;
    stb.stepUpper = running & tickEn;
    stb.loadLower = ~running | ~cascadeEn;
    stb.stepLower = running & cascadeEn & upperTc;
  end

  always_comb begin
    if (extPaceSel) paceEvt = masterEn & armed & xFall;
    else            paceEvt = cascadeEn ? lowerTc : upperTc;
    qualEvt = paceEvt & (~gateMode | gLevel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      convStart <= 1'b0;
      irqOut    <= 1'b0;
      trigSeen  <= 1'b0;
    end else begin
      convStart <= qualEvt;
      irqOut    <= intEn & ~extPaceSel & xRise;
      if (!(masterEn && trigMode)) trigSeen <= 1'b0;
      else if (gRise)              trigSeen <= 1'b1;
    end
  end

  // R4
  conv_needs_master_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> $past(masterEn));
  // R9
  gate_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && $past(gateMode)) |-> $past(gLevel));
  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(intEn && !extPaceSel));
  // R8
  trig_flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trigSeen) |-> !$past(masterEn && trigMode));
  // R8
  trig_flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigSeen) |-> $past(gRise));
endmodule

// File: rtl/pacer_trigger_ctrl.sv
module pacer_trigger_ctrl
  import pacer_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         masterEn,
  input  logic         extPaceSel,
  input  logic         cascadeEn,
  input  logic         trigEn,
  input  logic         gateEn,
  input  logic         intEn,
  input  logic [W-1:0] upperReload,
  input  logic [W-1:0] lowerReload,
  input  logic         xclkIn,
  input  logic         trigIn,
  output logic         convStart,
  output logic         irqOut,
  output logic         trigSeen
);
  divStrobes_t stb;
  logic upperTc, lowerTc;

  pacer_control u_ctl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .masterEn(masterEn),
    .extPaceSel(extPaceSel), .cascadeEn(cascadeEn), .trigEn(trigEn),
    .gateEn(gateEn), .intEn(intEn), .xclkIn(xclkIn), .trigIn(trigIn),
    .upperTc(upperTc), .lowerTc(lowerTc), .stb(stb),
    .convStart(convStart), .irqOut(irqOut), .trigSeen(trigSeen));

  pacer_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .upperReload(upperReload), .lowerReload(lowerReload),
    .upperTc(upperTc), .lowerTc(lowerTc));
endmodule

// File: tb/sim_pacer_trigger_ctrl.sv
`timescale 1ns/1ps
module sim_pacer_trigger_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 0, masterEn = 0, extPaceSel = 0, cascadeEn = 0;
  logic trigEn = 0, gateEn = 0, intEn = 0, xclkIn = 0, trigIn = 0;
  logic [15:0] upperReload = 16'd1, lowerReload = 16'd1;
  logic convStart, irqOut, trigSeen;

  int errors = 0, checks = 0;
  int convCnt = 0, irqCnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pacer_trigger_ctrl u0 (.*);

  always @(negedge clk) begin
    if (rstN && convStart) convCnt++;
    if (rstN && irqOut)    irqCnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n, input bit randGap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1;
      @(negedge clk); tickEn = 0;
      if (randGap) idle($urandom_range(0, 3));
    end
    idle(3);
  endtask

  task automatic pulseX(input int n);
    for (int i = 0; i < n; i++) begin
      xclkIn = 1; idle(4);
      xclkIn = 0; idle(4);
    end
  endtask

  function automatic int expPulses(int n, int u, int l, bit casc);
    int ue = (u == 0) ? 1 : u;
    int le = (l == 0) ? 1 : l;
    return casc ? n / (ue * le) : n / ue;
  endfunction

  // Run pacing from a fresh load and return pulses seen
  task automatic runPace(input int n, input bit gap, output int got);
    int c0;
    masterEn = 0; idle(2);
    masterEn = 1;
    c0 = convCnt;
    ticks(n, gap);
    got = convCnt - c0;
    masterEn = 0; idle(2);
  endtask

  initial begin
    int got, c0, i0;
    void'($urandom(32'd20240611));
    idle(3);
    // R1 reset state
    check("R1 convStart", convStart, 0);
    check("R1 irqOut", irqOut, 0);
    check("R1 trigSeen", trigSeen, 0);
    rstN = 1;
    @(negedge clk);
    check("R1 post-reset conv", convStart, 0);

    // R4 master off
    upperReload = 2; c0 = convCnt;
    ticks(10, 0);
    check("R4 no pulses disabled", convCnt - c0, 0);

    // R2 directed
    upperReload = 3; runPace(9, 0, got);
    check("R2 div3", got, 3);
    upperReload = 0; runPace(5, 0, got);
    check("R2 reload0 every tick", got, 5);
    upperReload = 1; runPace(4, 0, got);
    check("R2 reload1 every tick", got, 4);

    // R4 restart phase: partial period lost on disable
    upperReload = 4; runPace(3, 0, got);
    check("R4 partial", got, 0);
    runPace(4, 0, got);
    check("R4 restarts full period", got, 1);

    // R3 cascade directed
    cascadeEn = 1; upperReload = 3; lowerReload = 2;
    runPace(12, 0, got);
    check("R3 cascade 3x2", got, 2);
    cascadeEn = 0;

    // R2/R3 random
    for (int k = 0; k < 25; k++) begin
      int u, l, n; bit c;
      u = $urandom_range(0, 6); l = $urandom_range(0, 4);
      n = $urandom_range(0, 40); c = $urandom_range(0, 1);
      upperReload = 16'(u); lowerReload = 16'(l); cascadeEn = c;
      runPace(n, 1, got);
      check(c ? "R3 random cascade" : "R2 random single", got, expPulses(n, u, l, c));
    end
    cascadeEn = 0;

    // R10 gate ignored without trigger enable
    gateEn = 1; trigIn = 0; upperReload = 2;
    runPace(6, 0, got);
    check("R10 gateEn ignored", got, 3);
    gateEn = 0;

    // R7/R8 triggered
    trigEn = 1; gateEn = 0; upperReload = 2;
    masterEn = 1; idle(2); c0 = convCnt;
    ticks(10, 0);
    check("R7 no pulse before trigger", convCnt - c0, 0);
    check("R8 flag low before trigger", trigSeen, 0);
    trigIn = 1; idle(5);
    check("R8 flag set", trigSeen, 1);
    c0 = convCnt; ticks(10, 0);
    check("R7 pacing after trigger", convCnt - c0, 5);
    trigIn = 0; idle(4);
    check("R8 flag holds after trigger low", trigSeen, 1);
    masterEn = 0; idle(2);
    check("R8 flag cleared by master", trigSeen, 0);

    // R9 gated
    gateEn = 1; trigIn = 0; upperReload = 2;
    masterEn = 1; idle(2); c0 = convCnt;
    ticks(8, 0);
    check("R9 gate low blocks", convCnt - c0, 0);
    trigIn = 1; idle(4);
    c0 = convCnt; ticks(8, 0);
    check("R9 gate high passes", convCnt - c0, 4);
    masterEn = 0; trigEn = 0; gateEn = 0; trigIn = 0; idle(4);

    // R5 external pacer
    extPaceSel = 1; masterEn = 1; intEn = 1; idle(2);
    c0 = convCnt; i0 = irqCnt;
    pulseX(5);
    check("R5 one pulse per fall", convCnt - c0, 5);
    check("R6 no irq in pacer use", irqCnt - i0, 0);
    c0 = convCnt; ticks(6, 0);
    check("R5 ticks ignored", convCnt - c0, 0);
    // exact latency
    xclkIn = 1; idle(5);
    xclkIn = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R5 not before third edge", convStart, 0);
    @(posedge clk); @(negedge clk);
    check("R5 third edge", convStart, 1);
    idle(3);

    // R6 external interrupt
    extPaceSel = 0; masterEn = 0; idle(2);
    c0 = convCnt; i0 = irqCnt;
    pulseX(3);
    check("R6 irq per rise", irqCnt - i0, 3);
    check("R6 no conv from pin", convCnt - c0, 0);
    intEn = 0; i0 = irqCnt;
    pulseX(2);
    check("R6 irq off", irqCnt - i0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule